// File: doc/BRIEF.md
# Longest Prefix Match Lookup

This block is the route lookup stage of a packet forwarding pipeline. It keeps a small table of forwarding entries, each made of a valid flag, an address prefix, a prefix length and an output port number. A destination address offered on the request stream is compared against every entry at once. The result is the port of the best matching entry, or a configurable default port with a miss flag when no entry qualifies. The result leaves on a response stream one cycle after the request is accepted.

A two-bit mode input picks how entries are matched. In longest-prefix mode each entry is compared over its own prefix length, and the longest match wins. In fixed-length mode one shared length replaces every stored length. In exact mode the whole address must equal the stored prefix, as for flat link-layer addresses. Software or a control agent fills the table through a one-cycle write port.

Both streams use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held and `rsp_ready` is low. A response stays unchanged until it is taken. When `rsp_ready` is high, the block accepts one lookup per cycle.

Top module: `lpm_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1 and every table entry is invalid, so any lookup misses.
- R2: When `wr_en` is high at a clock edge, the entry at `wr_idx` takes `wr_valid`, `wr_prefix`, `wr_len` and `wr_port`. A lookup accepted on that same edge still sees the old entry. An entry written with `wr_valid`=0 never matches.
- R3: In longest-prefix mode (`mode`=0), a valid entry matches when its leading `len` address bits, counted from the MSB, equal those of the address. Bits below the prefix length are ignored. A length of 0 never matches. A length above the address width counts as the full width.
- R4: In longest-prefix mode, when several entries match, the entry with the greatest prefix length is chosen. For example, a 7-bit match beats a 5-bit match.
- R5: When the best matching entries have equal effective length, the lowest table index wins.
- R6: In fixed-length mode (`mode`=1), each entry is compared over `fixed_len` leading bits and its stored length is ignored. The lowest matching index wins. A `fixed_len` of 0 gives a miss.
- R7: In exact mode (`mode`=2, and also `mode`=3), a valid entry matches only when the whole address equals its prefix. The lowest matching index wins.
- R8: On a miss the response has `rsp_miss`=1 and `rsp_port` equal to `dflt_port` as sampled when the request was accepted. On a hit `rsp_miss`=0 and `rsp_port` is the chosen entry's port.
- R9: The response appears with `rsp_valid`=1 in the cycle after acceptance. It holds stable while `rsp_ready` is 0, and `req_ready` is low during that stall. With `rsp_ready` high, back-to-back requests give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid flag for the written entry |
| wr_prefix | input | ADDR_W | Prefix value for the written entry |
| wr_len | input | LEN_W | Prefix length for the written entry |
| wr_port | input | PORT_W | Output port for the written entry |
| mode | input | 2 | 0 longest-prefix, 1 fixed-length, 2 or 3 exact |
| fixed_len | input | LEN_W | Shared prefix length used in fixed-length mode |
| dflt_port | input | PORT_W | Port returned on a miss |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Destination address to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_port | output | PORT_W | Selected output port |
| rsp_miss | output | 1 | No entry matched |

## Verification
The assertions assume that all inputs are known after reset. They also assume that `mode`, `fixed_len` and `dflt_port` are treated as part of a request, so they may change between lookups but are sampled only at acceptance. `wr_idx` is expected to stay within the table depth. The bench drives every input on the falling edge, sets each mode field only together with the request it belongs to, and writes only to indices inside the table. It still lets `rsp_ready` drop while a request is pending, so that the stall rules are exercised.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_LONGEST = 2'd0,
    MODE_FIXED   = 2'd1,
    MODE_EXACT   = 2'd2,
    MODE_EXACT2  = 2'd3
  } lpm_mode_e;

  function automatic logic is_exact(input lpm_mode_e m);
    return (m == MODE_EXACT) || (m == MODE_EXACT2);
  endfunction
endpackage

// File: rtl/lpm_table.sv
module lpm_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  parameter int LEN_W   = 6,
  parameter int IDX_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic                             wr_valid,
  input  logic [ADDR_W-1:0]                wr_prefix,
  input  logic [LEN_W-1:0]                 wr_len,
  input  logic [PORT_W-1:0]                wr_port,
  output logic [ENTRIES-1:0]               ent_valid,
  output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_prefix,
  output logic [ENTRIES-1:0][LEN_W-1:0]    ent_len,
  output logic [ENTRIES-1:0][PORT_W-1:0]   ent_port
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel;
    assign sel = wr_en && (int'(wr_idx) == e);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[e]  <= 1'b0;
        ent_prefix[e] <= '0;
        ent_len[e]    <= '0;
        ent_port[e]   <= '0;
      end else if (sel) begin
        ent_valid[e]  <= wr_valid;
        ent_prefix[e] <= wr_prefix;
        ent_len[e]    <= wr_len;
        ent_port[e]   <= wr_port;
      end
    end
  end

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < ENTRIES && !wr_valid) |=> !$countones(ent_valid & (ENTRIES'(1) << $past(wr_idx))));
endmodule

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6
) (
  input  lpm_mode_e          mode,
  input  logic [LEN_W-1:0]   fixed_len,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               valid,
  input  logic [ADDR_W-1:0]  prefix,
  input  logic [LEN_W-1:0]   len,
  output logic               hit,
  output logic [LEN_W-1:0]   eff_len
);
  logic [LEN_W-1:0]  raw_len;
  logic [ADDR_W-1:0] care;

  always_comb begin
    if (mode == MODE_LONGEST)    raw_len = len;
    else if (mode == MODE_FIXED) raw_len = fixed_len;
    else                         raw_len = LEN_W'(ADDR_W);
  end

  always_comb begin
    if (int'(raw_len) > ADDR_W) eff_len = LEN_W'(ADDR_W);
    else                        eff_len = raw_len;
  end

  // bit b sits ADDR_W-1-b places below the MSB
  for (genvar b = 0; b < ADDR_W; b++) begin : g_care
    assign care[b] = (ADDR_W - 1 - b) < int'(eff_len);
  end

  assign hit = valid && (eff_len != '0) && (((addr ^ prefix) & care) == '0);

  // R7
  always_comb begin
    if (is_exact(mode) && hit) begin
      exact_full_chk: assert (addr == prefix);
    end
  end
endmodule

// File: rtl/lpm_select.sv
module lpm_select #(
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  parameter int LEN_W   = 6,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0]             hit,
  input  logic [ENTRIES-1:0][LEN_W-1:0]  eff_len,
  input  logic [ENTRIES-1:0][PORT_W-1:0] port,
  output logic [ENTRIES-1:0]             grant,
  output logic                           any_hit,
  output logic [PORT_W-1:0]              best_port
);
  logic [LEN_W-1:0] best_len;
  logic [IDX_W-1:0] best_idx;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    any_hit   = 1'b0;
    best_len  = '0;
    best_idx  = '0;
    best_port = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i] && (!any_hit || eff_len[i] > best_len)) begin
        any_hit   = 1'b1;
        best_len  = eff_len[i];
        best_idx  = IDX_W'(i);
        best_port = port[i];
      end
    end
    grant = any_hit ? (ENTRIES'(1) << best_idx) : '0;
  end
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  parameter int PORT_W  = 4,
  parameter int LEN_W   = $clog2(ADDR_W + 1),
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [1:0]        mode,
  input  logic [LEN_W-1:0]  fixed_len,
  input  logic [PORT_W-1:0] dflt_port,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PORT_W-1:0] rsp_port,
  output logic              rsp_miss
);
  lpm_mode_e mode_e;
  assign mode_e = lpm_mode_e'(mode);

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_prefix;
  logic [ENTRIES-1:0][LEN_W-1:0]  ent_len;
  logic [ENTRIES-1:0][PORT_W-1:0] ent_port;
  logic [ENTRIES-1:0]             hit;
  logic [ENTRIES-1:0][LEN_W-1:0]  eff_len;
  logic [ENTRIES-1:0]             grant;
  logic                           any_hit;
  logic [PORT_W-1:0]              best_port;
  logic                           accept;

  lpm_table #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .PORT_W(PORT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port),
    .ent_valid(ent_valid), .ent_prefix(ent_prefix), .ent_len(ent_len), .ent_port(ent_port)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    lpm_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_match (
      .mode(mode_e), .fixed_len(fixed_len), .addr(req_addr),
      .valid(ent_valid[e]), .prefix(ent_prefix[e]), .len(ent_len[e]),
      .hit(hit[e]), .eff_len(eff_len[e])
    );
  end

  lpm_select #(
    .ENTRIES(ENTRIES), .PORT_W(PORT_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) i_select (
    .hit(hit), .eff_len(eff_len), .port(ent_port),
    .grant(grant), .any_hit(any_hit), .best_port(best_port)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      rsp_miss  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_port  <= any_hit ? best_port : dflt_port;
      rsp_miss  <= !any_hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // checker: is there a hit entry that beats the granted one?
  logic better_exists;
  always_comb begin
    int g;
    g = 0;
    better_exists = 1'b0;
    for (int i = 0; i < ENTRIES; i++) if (grant[i]) g = i;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i] && (eff_len[i] > eff_len[g] || (eff_len[i] == eff_len[g] && i < g)))
        better_exists = 1'b1;
    end
  end

  // R4
  best_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (!better_exists && (grant & hit) == grant));
  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any_hit == (hit != '0)));
  // R8
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit == '0) |=> (rsp_miss && rsp_port == $past(dflt_port)));
  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_port) && $stable(rsp_miss)));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/test_lpm_lookup.sv
module test_lpm_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NE = 8;
  localparam int PW = 3;
  localparam int LW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_valid = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_prefix = '0;
  logic [LW-1:0] wr_len = '0;
  logic [PW-1:0] wr_port = '0;
  logic [1:0] mode = 2'd0;
  logic [LW-1:0] fixed_len = '0;
  logic [PW-1:0] dflt_port = 3'd7;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_miss;
  logic [PW-1:0] rsp_port;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_lookup #(.ADDR_W(AW), .ENTRIES(NE), .PORT_W(PW)) i_lpm_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_prefix(wr_prefix), .wr_len(wr_len), .wr_port(wr_port), .mode(mode),
    .fixed_len(fixed_len), .dflt_port(dflt_port), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_port(rsp_port), .rsp_miss(rsp_miss)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic v, input logic [AW-1:0] p,
                             input int len, input int port);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_valid = v; wr_prefix = p;
    wr_len = LW'(len); wr_port = PW'(port);
    @(negedge clk);
    wr_en = 0;
  endtask

  // result packed as {rsp_valid, rsp_miss, rsp_port}
  task automatic lookup_chk(input string tag, input logic [AW-1:0] a, input int m,
                            input logic exp_miss, input int exp_port);
    @(negedge clk);
    req_addr = a; mode = 2'(m); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(tag, {rsp_valid, rsp_miss, rsp_port}, {1'b1, exp_miss, PW'(exp_port)});
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 req_ready after reset", req_ready, 1);
    lookup_chk("R1 empty table misses", 8'h00, 0, 1, 7);
    lookup_chk("R1 empty table misses exact", 8'hFF, 2, 1, 7);
  endtask

  task automatic t_longest;
    write_entry(0, 1, 8'hD0, 4, 1);
    write_entry(1, 1, 8'hC0, 2, 2);
    write_entry(2, 1, 8'hC8, 7, 3);
    write_entry(3, 1, 8'h40, 2, 4);
    write_entry(4, 1, 8'hCC, 5, 5);
    lookup_chk("R4 7-bit beats 5 and 2", 8'hC9, 0, 0, 3);
    lookup_chk("R4 4-bit beats 2", 8'hD9, 0, 0, 1);
    lookup_chk("R3 2-bit match after first-bit mismatches", 8'h65, 0, 0, 4);
    lookup_chk("R8 no match gives default", 8'h80, 0, 1, 7);
  endtask

  task automatic t_ties_and_edges;
    write_entry(5, 1, 8'hD0, 4, 6);
    lookup_chk("R5 tie lowest index", 8'hD9, 0, 0, 1);
    write_entry(0, 0, 8'hD0, 4, 1);
    lookup_chk("R2 invalidated entry skipped", 8'hD9, 0, 0, 6);
    write_entry(6, 1, 8'h00, 0, 2);
    lookup_chk("R3 zero length never matches", 8'h80, 0, 1, 7);
    write_entry(7, 1, 8'h8F, 4, 5);
    lookup_chk("R3 bits below length ignored", 8'h80, 0, 0, 5);
    write_entry(6, 1, 8'h3C, 15, 3);
    lookup_chk("R3 oversize length is full width", 8'h3C, 0, 0, 3);
    lookup_chk("R3 oversize length last bit differs", 8'h3D, 0, 1, 7);
  endtask

  task automatic t_fixed;
    fixed_len = 4'd4;
    lookup_chk("R6 fixed ignores stored length", 8'hC9, 1, 0, 2);
    lookup_chk("R6 fixed 4 bits", 8'hD9, 1, 0, 6);
    fixed_len = 4'd0;
    lookup_chk("R6 fixed length zero misses", 8'hC9, 1, 1, 7);
  endtask

  task automatic t_exact;
    lookup_chk("R7 exact hit", 8'hCC, 2, 0, 5);
    lookup_chk("R7 exact near miss", 8'hC9, 2, 1, 7);
    lookup_chk("R7 exact uses full prefix", 8'h8F, 2, 0, 5);
    lookup_chk("R7 mode 3 is exact", 8'hCC, 3, 0, 5);
    dflt_port = 3'd0;
    lookup_chk("R8 default sampled at accept", 8'h81, 2, 1, 0);
    dflt_port = 3'd7;
  endtask

  task automatic t_same_cycle_write;
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd2; wr_valid = 0; wr_prefix = 8'hC8; wr_len = 4'd7; wr_port = 3'd3;
    req_addr = 8'hC9; mode = 2'd0; req_valid = 1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check("R2 same-cycle lookup sees old entry", {rsp_valid, rsp_miss, rsp_port}, {2'b10, 3'd3});
    lookup_chk("R2 next lookup sees new entry", 8'hC9, 0, 0, 5);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    rsp_ready = 0; req_addr = 8'hCC; mode = 2'd2; req_valid = 1;
    @(negedge clk);
    check("R9 response after one cycle", {rsp_valid, rsp_miss, rsp_port}, {2'b10, 3'd5});
    check("R9 ready low while stalled", req_ready, 0);
    req_addr = 8'hC9;
    @(negedge clk);
    check("R9 response held", {rsp_valid, rsp_miss, rsp_port}, {2'b10, 3'd5});
    check("R9 still stalled", req_ready, 0);
    rsp_ready = 1;
    #1;
    check("R9 ready follows rsp_ready", req_ready, 1);
    @(negedge clk);
    check("R9 pending request taken", {rsp_valid, rsp_miss, rsp_port}, {2'b11, 3'd7});
    req_addr = 8'h3C;
    @(negedge clk);
    check("R9 back-to-back", {rsp_valid, rsp_miss, rsp_port}, {2'b10, 3'd3});
    req_valid = 0;
    @(negedge clk);
    check("R9 valid drops when idle", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_longest();
    t_ties_and_edges();
    t_fixed();
    t_exact();
    t_same_cycle_write();
    t_handshake();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule